// File: doc/BRIEF.md
# Clock Multiplier Control Registers with Feed-Commit

This block is the software-facing control plane of a clock multiplier. Software writes an enable and a connect bit into a control register, and a multiplier M and a divider P into a configuration register. These writes only land in pending storage. The values that drive the multiplier are held in a separate set of effective registers. They change only when software writes an unlock key and then a commit key to a feed register. The commit key copies every pending field into the effective set in a single clock edge.

A read-only status register shows the effective M, P, enable and connect values together with the lock input that comes back from the multiplier. Software can therefore tell what is actually in force, which may differ from what it has written. The block does not wait for lock before connecting, and it never drops connect on its own when lock is lost. Those policies are left to software. The bus port is a single-cycle synchronous write/read port with combinational read data.

The feed sequencer has two states. ST_IDLE is the reset state. ST_ARMED is reached after a valid unlock key. The transitions are:
- ARM: ST_IDLE to ST_ARMED on a feed write of the unlock key.
- HOLD: stays in ST_ARMED on cycles with no bus access.
- COMMIT: ST_ARMED to ST_IDLE on a feed write of the commit key. This transition loads the effective registers.
- ABORT: ST_ARMED to ST_IDLE on any other read or write.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, the enable, connect, M and P outputs are 0. Reads of the control, configuration and status registers return 0, apart from status bit 10, which follows the lock input.
- R2: The word at `bus_addr` 0 is the control register, with enable at bit 0 and connect at bit 1. Reading it returns the pending values last written.
- R3: The word at `bus_addr` 1 is the configuration register, with M at bits 4:0 and P at bits 6:5. Reading it returns the pending values last written.
- R4: Writes to the control or configuration register leave the enable, connect, M and P outputs unchanged until a valid feed.
- R5: A valid feed has two steps. First, a write of the whole word 0x000000AA to `bus_addr` 3. Then, as the very next bus access, a write of 0x00000055 to `bus_addr` 3. Idle cycles between the two writes are allowed. On the clock edge of the second write, all pending fields become effective together.
- R6: After 0xAA has been written to the feed register, any read, any write to another register, or a feed write of any value other than 0x55 cancels the sequence. No output changes. A later complete sequence still commits.
- R7: The word at `bus_addr` 2 is read-only status. It holds effective M at bits 4:0, effective P at bits 6:5, the enable output at bit 8, the connect output at bit 9 and the lock input at bit 10. Writes to it change nothing.
- R8: The connect output, and status bit 9, are 0 whenever the effective enable is 0.
- R9: A commit with enable and connect both set drives connect high whatever the lock input is. A later fall of lock does not clear connect.
- R10: Reserved bits read as 0: control bits 31:2, configuration bits 31:7 and status bits 31:11 and 7. The feed register reads as 0. Ones written to reserved bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word index: 0 control, 1 configuration, 2 status, 3 feed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd`, 0 otherwise |
| pll_lock | input | 1 | Lock indication from the multiplier |
| pll_en | output | 1 | Effective enable |
| pll_conn | output | 1 | Effective connect, gated by the effective enable |
| pll_m | output | 5 | Effective multiplier M |
| pll_p | output | 2 | Effective divider P |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 2-bit word address, and 0xAA and 0x55 as the two feed keys. These values fit the full M and P field widths and leave reserved bits above them. The bench can then write ones into every reserved position. They also leave one spare key value, 0x56, to use as a near-miss commit. With only four addresses, every register can serve as an interrupting access between the two feed writes. The lock input is driven freely against the reference model, so lock can fall while the block is connected.

// File: rtl/pllfc_pkg.sv
package pllfc_pkg;

    localparam int M_W = 5;
    localparam int P_W = 2;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_FEED = 2'd3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } feed_state_e;

    typedef struct packed {
        logic           en;
        logic           conn;
        logic [M_W-1:0] m;
        logic [P_W-1:0] p;
    } pll_set_t;

endpackage

// File: rtl/pllfc_feed_seq.sv
module pllfc_feed_seq #(
    parameter int          DATA_W   = 32,
    parameter logic [7:0]  KEY_ARM  = 8'hAA,
    parameter logic [7:0]  KEY_GO   = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic              acc_feed,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit
);
    import pllfc_pkg::*;

    localparam logic [DATA_W-1:0] ARM_WORD = DATA_W'(KEY_ARM);
    localparam logic [DATA_W-1:0] GO_WORD  = DATA_W'(KEY_GO);

    feed_state_e state_q, state_d;
    logic        any_acc;
    logic        arm_hit;
    logic        go_hit;

    assign any_acc = acc_wr | acc_rd;
    assign arm_hit = acc_wr & acc_feed & (wdata == ARM_WORD);
    assign go_hit  = acc_wr & acc_feed & (wdata == GO_WORD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_hit) begin
                    state_d = ST_ARMED;              // ARM
                end
            end
            ST_ARMED: begin
                if (any_acc) begin
                    state_d = ST_IDLE;               // COMMIT or ABORT
                end                                  // else HOLD
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE:  commit = 1'b0;
            ST_ARMED: commit = go_hit;
            default:  commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pllfc_pend_regs.sv
module pllfc_pend_regs (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic                 wr_cfg,
    input  logic [1:0]           ctrl_bits,
    input  logic [pllfc_pkg::M_W+pllfc_pkg::P_W-1:0] cfg_bits,
    output pllfc_pkg::pll_set_t  pend
);
    import pllfc_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            if (wr_ctrl) begin
                pend.en   <= ctrl_bits[0];
                pend.conn <= ctrl_bits[1];
            end
            if (wr_cfg) begin
                pend.m <= cfg_bits[M_W-1:0];
                pend.p <= cfg_bits[M_W+P_W-1:M_W];
            end
        end
    end

endmodule

// File: rtl/pllfc_live_regs.sv
module pllfc_live_regs (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  pllfc_pkg::pll_set_t pend,
    output pllfc_pkg::pll_set_t live
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= '0;
        end else if (commit) begin
            live <= pend;
        end
    end

endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs #(
    parameter int         DATA_W  = 32,
    parameter int         ADDR_W  = 2,
    parameter logic [7:0] KEY_ARM = 8'hAA,
    parameter logic [7:0] KEY_GO  = 8'h55
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      pll_lock,
    output logic                      pll_en,
    output logic                      pll_conn,
    output logic [pllfc_pkg::M_W-1:0] pll_m,
    output logic [pllfc_pkg::P_W-1:0] pll_p
);
    import pllfc_pkg::*;

    localparam int CFG_W = M_W + P_W;

    pll_set_t pend;
    pll_set_t live;
    logic     commit;
    logic     conn_eff;
    logic     sel_ctrl, sel_cfg, sel_stat, sel_feed;

    assign sel_ctrl = (bus_addr == ADDR_W'(A_CTRL));
    assign sel_cfg  = (bus_addr == ADDR_W'(A_CFG));
    assign sel_stat = (bus_addr == ADDR_W'(A_STAT));
    assign sel_feed = (bus_addr == ADDR_W'(A_FEED));

    pllfc_feed_seq #(
        .DATA_W  (DATA_W),
        .KEY_ARM (KEY_ARM),
        .KEY_GO  (KEY_GO)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_wr   (bus_wr),
        .acc_rd   (bus_rd),
        .acc_feed (sel_feed),
        .wdata    (bus_wdata),
        .commit   (commit)
    );

    pllfc_pend_regs u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (bus_wr & sel_ctrl),
        .wr_cfg    (bus_wr & sel_cfg),
        .ctrl_bits (bus_wdata[1:0]),
        .cfg_bits  (bus_wdata[CFG_W-1:0]),
        .pend      (pend)
    );

    pllfc_live_regs u_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .pend   (pend),
        .live   (live)
    );

    assign conn_eff = live.conn & live.en;
    assign pll_en   = live.en;
    assign pll_conn = conn_eff;
    assign pll_m    = live.m;
    assign pll_p    = live.p;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_ctrl) begin
                bus_rdata[1:0] = {pend.conn, pend.en};
            end else if (sel_cfg) begin
                bus_rdata[CFG_W-1:0] = {pend.p, pend.m};
            end else if (sel_stat) begin
                bus_rdata[CFG_W-1:0] = {live.p, live.m};
                bus_rdata[8]         = live.en;
                bus_rdata[9]         = conn_eff;
                bus_rdata[10]        = pll_lock;
            end
        end
    end

endmodule

// File: rtl/pll_feed_regs_chk.sv
module pll_feed_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        pll_lock,
    input logic        pll_en,
    input logic        pll_conn,
    input logic [4:0]  pll_m,
    input logic [1:0]  pll_p
);
    logic go_wr;
    assign go_wr = bus_wr && (bus_addr == 2'd3) && (bus_wdata == 32'h55);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!pll_en && !pll_conn && pll_m == 5'd0 && pll_p == 2'd0));

    // R4 and R6: outputs move only on the edge after a commit-key write
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pll_en, pll_conn, pll_m, pll_p}) |-> $past(go_wr));

    p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2) |->
        (bus_rdata[10:0] == {pll_lock, pll_conn, pll_en, 1'b0, pll_p, pll_m}));

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_conn |-> pll_en);

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pll_lock) && $past(pll_conn) && !$past(go_wr)) |-> pll_conn);

    p_resv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |-> (bus_rdata[31:2] == 30'd0));

endmodule

bind pll_feed_regs pll_feed_regs_chk u_chk (.*);

// File: tb/tb_pll_feed_regs.sv
`timescale 1ns/1ps
module tb_pll_feed_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pll_lock;
    logic        pll_en, pll_conn;
    logic [4:0]  pll_m;
    logic [1:0]  pll_p;

    int checks = 0;
    int errors = 0;

    // reference model state
    int pe_en, pe_conn, pe_m, pe_p;
    int ef_en, ef_conn, ef_m, ef_p;
    int armed;

    always #2.5 clk = ~clk;

    pll_feed_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_lock(pll_lock), .pll_en(pll_en), .pll_conn(pll_conn),
        .pll_m(pll_m), .pll_p(pll_p)
    );

    task automatic chk(input longint act, input longint exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint model_read(input int a);
        int c;
        c = (ef_en != 0 && ef_conn != 0) ? 1 : 0;
        case (a)
            0: return pe_en + 2 * pe_conn;
            1: return pe_m + 32 * pe_p;
            2: return ef_m + 32 * ef_p + 256 * ef_en + 512 * c + 1024 * int'(pll_lock);
            default: return 0;
        endcase
    endfunction

    task automatic check_outs(input string tag);
        int c;
        c = (ef_en != 0 && ef_conn != 0) ? 1 : 0;
        chk({pll_en, pll_conn, pll_m, pll_p},
            {ef_en[0], c[0], ef_m[4:0], ef_p[1:0]}, tag);
    endtask

    task automatic model_update(input logic wr, input logic rd, input int a, input int d);
        if (wr && a == 0) begin pe_en = d & 1; pe_conn = (d >> 1) & 1; end
        if (wr && a == 1) begin pe_m = d & 31; pe_p = (d >> 5) & 3; end
        if (wr && a == 3) begin
            if (armed != 0 && d == 32'h55) begin
                ef_en = pe_en; ef_conn = pe_conn; ef_m = pe_m; ef_p = pe_p;
                armed = 0;
            end else begin
                armed = (armed == 0 && d == 32'hAA) ? 1 : 0;
            end
        end else if (wr || rd) begin
            armed = 0;
        end
    endtask

    task automatic step(input logic wr, input logic rd, input int a,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        check_outs(tag);
        bus_wr = wr; bus_rd = rd; bus_addr = a[1:0]; bus_wdata = d;
        #1;
        if (rd) chk(bus_rdata, model_read(a), tag);
        @(posedge clk);
        model_update(wr, rd, a, int'(d));
        #1;
        bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, a, d, tag);
    endtask
    task automatic rd(input int a, input string tag);
        step(1'b0, 1'b1, a, 32'h0, tag);
    endtask
    task automatic idle(input string tag);
        step(1'b0, 1'b0, 0, 32'h0, tag);
    endtask

    task automatic expect_outs(input int en, input int c, input int m, input int p,
                               input string tag);
        @(negedge clk);
        chk({pll_en, pll_conn, pll_m, pll_p}, {en[0], c[0], m[4:0], p[1:0]}, tag);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; pll_lock = 0;
        pe_en = 0; pe_conn = 0; pe_m = 0; pe_p = 0;
        ef_en = 0; ef_conn = 0; ef_m = 0; ef_p = 0; armed = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        expect_outs(0, 0, 0, 0, "R1 reset outputs");
        rd(0, "R1 ctrl reset"); rd(1, "R1 cfg reset"); rd(2, "R1 status reset");

        wr(0, 32'hFFFF_FFFF, "R2 R10 ctrl write");
        wr(1, 32'hFFFF_FF80 | 32'h4D, "R3 R10 cfg write");
        rd(0, "R2 R10 ctrl readback"); rd(1, "R3 R10 cfg readback");
        rd(3, "R10 feed reads zero");
        expect_outs(0, 0, 0, 0, "R4 pending not applied");
        rd(2, "R7 status still old");

        wr(3, 32'hAA, "R5 arm"); idle("R5 hold"); idle("R5 hold");
        wr(3, 32'h55, "R5 commit");
        expect_outs(1, 1, 13, 2, "R5 R9 commit applied unlocked");
        rd(2, "R7 status after commit");
        wr(2, 32'hFFFF_FFFF, "R7 status write ignored");
        rd(2, "R7 status unchanged");

        wr(1, 32'h07, "R6 new cfg");
        wr(3, 32'hAA, "R6 arm"); rd(0, "R6 read aborts"); wr(3, 32'h55, "R6 late key");
        expect_outs(1, 1, 13, 2, "R6 abort by read");
        wr(3, 32'hAA, "R6 arm"); wr(3, 32'h56, "R6 wrong key"); wr(3, 32'h55, "R6 late key");
        expect_outs(1, 1, 13, 2, "R6 abort by wrong key");
        wr(3, 32'hAA, "R6 arm"); wr(3, 32'hAA, "R6 double arm"); wr(3, 32'h55, "R6 late key");
        expect_outs(1, 1, 13, 2, "R6 abort by repeat arm");
        wr(3, 32'hAA, "R6 arm"); wr(1, 32'h07, "R6 cfg aborts"); wr(3, 32'h55, "R6 late key");
        expect_outs(1, 1, 13, 2, "R6 abort by cfg write");
        wr(3, 32'h155, "R6 stray"); wr(3, 32'hAA, "R6 arm"); wr(3, 32'h55, "R6 recommit");
        expect_outs(1, 1, 7, 0, "R6 later sequence commits");

        wr(0, 32'h2, "R8 conn without en");
        wr(3, 32'hAA, "R8 arm"); wr(3, 32'h55, "R8 commit");
        expect_outs(0, 0, 7, 0, "R8 conn gated");
        rd(2, "R8 status conn bit");

        pll_lock = 1;
        wr(0, 32'h3, "R9 ctrl"); wr(3, 32'hAA, "R9 arm"); wr(3, 32'h55, "R9 commit");
        expect_outs(1, 1, 7, 0, "R9 connected");
        rd(2, "R9 status locked");
        pll_lock = 0;
        idle("R9 lock lost"); idle("R9 lock lost");
        expect_outs(1, 1, 7, 0, "R9 connect kept");
        rd(2, "R9 status unlocked");

        idle("final"); idle("final");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule